// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block runs single bus cycles to an 8-bit NAND flash device. A host presents one request at a time. The request says whether the cycle latches a command, latches an address, or moves data, and in which direction. The block then drives the device's latch enables, its active-low chip enables, write strobe and read strobe, and the output enable of the bidirectional data bus. When the cycle is complete it returns the captured read byte and a one-cycle completion pulse.

Every cycle passes through three phases: a setup phase, a strobe phase and a hold phase. Each phase length comes from its own 8-bit timing field. The strobe phase stretches for as long as the device's wait input is active. Write cycles can hold the data bus in high impedance for a programmable number of cycles from the start of the access. A read that follows a command or address latch first waits through a 4-bit latch-to-read turnaround delay. All timing fields, the bank number and the write byte are captured when the request is accepted.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, and in every idle cycle, `busy` and `done` are 0, `ce_n` is all ones, `we_n` and `re_n` are 1, `cle`, `ale` and `dq_oe` are 0, and `rdata` is 0 until the first read completes. Reset also clears the record of the last latch cycle.
- R2: `req_kind` uses the codes 2'b00 for command, 2'b01 for address, and 2'b10 or 2'b11 for data. After acceptance, the setup phase lasts `cfg_setup`+1 cycles with both strobes high. `cle` is high from the setup phase through the hold phase for a command, `ale` likewise for an address, and neither is high for data.
- R3: The strobe phase lasts `cfg_wait`+1 cycles when `dev_wait` stays low. `we_n` is the strobe for command, address and data writes (`req_write`=1). `re_n` is the strobe only for data reads (`req_write`=0). The two strobes are never low together.
- R4: Every rising edge in the strobe phase at which `dev_wait` is 1 pauses the strobe counter, so the strobe lasts one extra cycle for each such edge.
- R5: The hold phase lasts `cfg_hold`+1 cycles with both strobes high. `done` is high for exactly one cycle, the first idle cycle after the hold phase.
- R6: On write cycles (command, address or data write), `dq_oe` is 0 for exactly `cfg_hiz` cycles from the first busy cycle, or for the whole access if it is shorter. After that it stays 1 until the access ends. `dq_out` carries the write byte throughout. Read cycles never raise `dq_oe`.
- R7: A data read whose previous access latched a command starts with an extra `cfg_cmd_rd_dly`+1 cycles before setup. If the previous access latched an address, the extra time is `cfg_adr_rd_dly`+1 cycles. Both fields are 4 bits. A read after a data access, or the first read after reset, adds no delay.
- R8: `rdata` takes the value of `dq_in` at the last strobe cycle of a read. Changes on `dq_in` after `re_n` rises do not alter it.
- R9: While busy, exactly the `ce_n` bit indexed by the captured `req_bank` is 0.
- R10: A request is accepted only when idle. Requests raised while busy are ignored, and timing fields changed during an access do not affect that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when idle |
| req_kind | input | 2 | 00 command, 01 address, 1x data |
| req_write | input | 1 | Direction for data cycles, 1 = write |
| req_wdata | input | 8 | Byte to drive on write cycles |
| req_bank | input | 2 | Chip-enable index |
| cfg_cmd_rd_dly | input | 4 | Command-latch to read delay, N+1 cycles |
| cfg_adr_rd_dly | input | 4 | Address-latch to read delay, N+1 cycles |
| cfg_hiz | input | 8 | Write bus turnaround, exactly N cycles |
| cfg_setup | input | 8 | Setup phase, N+1 cycles |
| cfg_wait | input | 8 | Strobe phase, N+1 cycles |
| cfg_hold | input | 8 | Hold phase, N+1 cycles |
| dev_wait | input | 1 | Device wait, pauses the strobe when 1 |
| dq_in | input | 8 | Data bus input |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 4 | Active-low chip enables |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |

## Verification
The assertions assume that `dev_wait` and `dq_in` are synchronous to `clk`. They also assume that `req_bank` stays below the number of banks and that `dev_wait` eventually falls, so a strobe ends. The stimulus meets these conditions. It changes every input only on the falling clock edge. It always releases `dev_wait` after a bounded stall that starts on the first strobe cycle. It keeps the wait input low outside the strobe phase, apart from what a stall leaves behind. The bench follows the latch history through its own model of the access sequence, and it places its mid-access disturbances (a competing request, changed timing fields, a new bus value after the read strobe) only in phases where the requirements say they have no effect.

// File: rtl/nseq_pkg.sv
// Package: shared types for the NAND access sequencer.
// Assumes: request kinds use codes 00 command, 01 address, 1x data.
package nseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4
    } nseq_state_e;

    typedef enum logic [1:0] {
        LL_NONE = 2'd0,
        LL_CMD  = 2'd1,
        LL_ADDR = 2'd2
    } nseq_latch_e;

    localparam logic [1:0] KIND_CMD  = 2'b00;
    localparam logic [1:0] KIND_ADDR = 2'b01;

endpackage

// File: rtl/nseq_dcount.sv
// Module: loadable down counter that stops at zero.
// Assumes: load takes priority over counting; zero is a decode of the count.
module nseq_dcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Count register: load, or step down towards zero when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero flag for the phase controller.
    always_comb begin
        zero = (cnt_q == '0);
    end

endmodule

// File: rtl/nseq_ce_dec.sv
// Module: active-low chip enable decoder.
// Assumes: sel is below N; all enables are high when not active.
module nseq_ce_dec #(
    parameter int N  = 4,
    parameter int BW = 2
) (
    input  logic          active,
    input  logic [BW-1:0] sel,
    output logic [N-1:0]  ce_n
);

    for (genvar i = 0; i < N; i++) begin : g_ce
        // One enable per bank, low only for the selected bank during an access.
        assign ce_n[i] = !(active && (sel == BW'(i)));
    end

endmodule

// File: rtl/nseq_fsm.sv
// Module: phase controller for one NAND access.
// Runs optional turnaround, setup, strobe and hold phases. Captures the
// request and timing fields at acceptance and records the last latch kind.
// Assumes: the phase counter reports zero one cycle after a load of 0.
module nseq_fsm
    import nseq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DLY_W  = 4,
    parameter int BANK_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [DLY_W-1:0]  cfg_cmd_rd_dly,
    input  logic [DLY_W-1:0]  cfg_adr_rd_dly,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              dev_wait,
    input  logic              ph_zero,
    input  logic [DATA_W-1:0] dq_in,
    output nseq_state_e       state,
    output logic              ph_load,
    output logic [CNT_W-1:0]  ph_val,
    output logic              ph_en,
    output logic              accept,
    output logic [1:0]        kind_q,
    output logic              wr_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    localparam int PAD_W = CNT_W - DLY_W;

    nseq_state_e     st_q;
    nseq_latch_e     last_q;
    logic [CNT_W-1:0] setup_q, wait_q, hold_q;
    logic             req_is_rd;
    logic             need_turn;
    logic [DLY_W-1:0] dly_sel;
    logic             strobe_end;

    // Request decode at the idle boundary.
    always_comb begin
        accept     = (st_q == ST_IDLE) && req_valid;
        req_is_rd  = req_kind[1] && !req_write;
        need_turn  = req_is_rd && (last_q != LL_NONE);
        dly_sel    = (last_q == LL_CMD) ? cfg_cmd_rd_dly : cfg_adr_rd_dly;
        strobe_end = (st_q == ST_STROBE) && ph_zero && !dev_wait;
        ph_en      = (st_q != ST_STROBE) || !dev_wait;
        state      = st_q;
    end

    // Phase counter load selection at each phase boundary.
    always_comb begin
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                ph_load = req_valid;
                ph_val  = need_turn ? {{PAD_W{1'b0}}, dly_sel} : cfg_setup;
            end
            ST_TURN: begin
                ph_load = ph_zero;
                ph_val  = setup_q;
            end
            ST_SETUP: begin
                ph_load = ph_zero;
                ph_val  = wait_q;
            end
            ST_STROBE: begin
                ph_load = strobe_end;
                ph_val  = hold_q;
            end
            default: begin
                ph_load = 1'b0;
                ph_val  = '0;
            end
        endcase
    end

    // Phase sequencing, request capture, read capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            last_q  <= LL_NONE;
            setup_q <= '0;
            wait_q  <= '0;
            hold_q  <= '0;
            kind_q  <= KIND_CMD;
            wr_q    <= 1'b0;
            bank_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        setup_q <= cfg_setup;
                        wait_q  <= cfg_wait;
                        hold_q  <= cfg_hold;
                        kind_q  <= req_kind;
                        wr_q    <= !req_is_rd;
                        bank_q  <= req_bank;
                        wdata_q <= req_wdata;
                        st_q    <= need_turn ? ST_TURN : ST_SETUP;
                    end
                end
                ST_TURN: begin
                    if (ph_zero) st_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (ph_zero) st_q <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (strobe_end) begin
                        st_q <= ST_HOLD;
                        if (!wr_q) rdata <= dq_in;
                    end
                end
                ST_HOLD: begin
                    if (ph_zero) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                        if (kind_q == KIND_CMD)       last_q <= LL_CMD;
                        else if (kind_q == KIND_ADDR) last_q <= LL_ADDR;
                        else                          last_q <= LL_NONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_strobe_seq.sv
// Module: top of the NAND access timing sequencer.
// Combines the phase controller, a phase counter, a write turnaround counter
// and the chip enable decoder. Pin outputs are decoded from registered state.
// Assumes: dev_wait and dq_in are synchronous to clk.
module nand_strobe_seq
    import nseq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 8,
    parameter int DLY_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [DLY_W-1:0]     cfg_cmd_rd_dly,
    input  logic [DLY_W-1:0]     cfg_adr_rd_dly,
    input  logic [CNT_W-1:0]     cfg_hiz,
    input  logic [CNT_W-1:0]     cfg_setup,
    input  logic [CNT_W-1:0]     cfg_wait,
    input  logic [CNT_W-1:0]     cfg_hold,
    input  logic                 dev_wait,
    input  logic [DATA_W-1:0]    dq_in,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic                 cle,
    output logic                 ale,
    output logic [NUM_BANKS-1:0] ce_n,
    output logic                 we_n,
    output logic                 re_n,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe
);

    nseq_state_e       state;
    logic              ph_load, ph_en, ph_zero, accept;
    logic [CNT_W-1:0]  ph_val;
    logic [1:0]        kind_q;
    logic              wr_q;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] wdata_q;
    logic              hz_zero;
    logic              latch_ph;

    nseq_fsm #(
        .CNT_W (CNT_W),
        .DLY_W (DLY_W),
        .BANK_W(BANK_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .req_bank      (req_bank),
        .cfg_cmd_rd_dly(cfg_cmd_rd_dly),
        .cfg_adr_rd_dly(cfg_adr_rd_dly),
        .cfg_setup     (cfg_setup),
        .cfg_wait      (cfg_wait),
        .cfg_hold      (cfg_hold),
        .dev_wait      (dev_wait),
        .ph_zero       (ph_zero),
        .dq_in         (dq_in),
        .state         (state),
        .ph_load       (ph_load),
        .ph_val        (ph_val),
        .ph_en         (ph_en),
        .accept        (accept),
        .kind_q        (kind_q),
        .wr_q          (wr_q),
        .bank_q        (bank_q),
        .wdata_q       (wdata_q),
        .rdata         (rdata),
        .done          (done)
    );

    // Phase length counter shared by all phases.
    nseq_dcount #(.W(CNT_W)) u_phase_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ph_load),
        .load_val(ph_val),
        .en      (ph_en),
        .zero    (ph_zero)
    );

    // Write turnaround counter, runs in parallel from the first busy cycle.
    nseq_dcount #(.W(CNT_W)) u_hiz_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(cfg_hiz),
        .en      (busy),
        .zero    (hz_zero)
    );

    nseq_ce_dec #(
        .N (NUM_BANKS),
        .BW(BANK_W)
    ) u_ce_dec (
        .active(busy),
        .sel   (bank_q),
        .ce_n  (ce_n)
    );

    // Pin decode from the registered phase state.
    always_comb begin
        busy     = (state != ST_IDLE);
        latch_ph = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        cle      = latch_ph && (kind_q == KIND_CMD);
        ale      = latch_ph && (kind_q == KIND_ADDR);
        we_n     = !((state == ST_STROBE) && wr_q);
        re_n     = !((state == ST_STROBE) && !wr_q);
        dq_out   = wdata_q;
        dq_oe    = busy && wr_q && hz_zero;
    end

endmodule

// File: rtl/nand_strobe_seq_chk.sv
// Module: property checker for the NAND access sequencer, bound to the top.
// Assumes: dev_wait is synchronous and eventually released.
module nand_strobe_seq_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic                 cle,
    input logic                 ale,
    input logic [NUM_BANKS-1:0] ce_n,
    input logic                 we_n,
    input logic                 re_n,
    input logic                 dq_oe,
    input logic                 dev_wait
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ce_n == '1 && we_n && re_n && !cle && !ale && !dq_oe));

    a_r2_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    a_r4_wait_keeps_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && dev_wait) |=> !we_n);

    a_r4_wait_keeps_re: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_n && dev_wait) |=> !re_n);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

    a_r9_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    a_r9_bank_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(~ce_n) == 1));

endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .cle     (cle),
    .ale     (ale),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .re_n    (re_n),
    .dq_oe   (dq_oe),
    .dev_wait(dev_wait)
);

// File: tb/nand_strobe_seq_bench.sv
module nand_strobe_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [1:0] kind;
        logic       wr;
        logic [1:0] bank;
        logic [7:0] wdata;
        logic [7:0] setup;
        logic [7:0] wt;
        logic [7:0] hold;
        logic [7:0] hiz;
        logic [3:0] clr;
        logic [3:0] alr;
        logic [7:0] stall;
        logic [7:0] rdv;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b1, 2'd0, 8'h70, 8'd0,   8'd0,   8'd0,   8'd0,   4'd3,  4'd0, 8'd0, 8'h00},
        '{2'b10, 1'b0, 2'd0, 8'h00, 8'd1,   8'd2,   8'd1,   8'd0,   4'd3,  4'd0, 8'd0, 8'hA5},
        '{2'b01, 1'b1, 2'd2, 8'h12, 8'd2,   8'd1,   8'd2,   8'd3,   4'd0,  4'd0, 8'd2, 8'h00},
        '{2'b10, 1'b0, 2'd2, 8'h00, 8'd0,   8'd0,   8'd0,   8'd0,   4'd0,  4'd5, 8'd1, 8'h3C},
        '{2'b11, 1'b0, 2'd2, 8'h00, 8'd3,   8'd3,   8'd0,   8'd0,   4'd9,  4'd9, 8'd0, 8'hC3},
        '{2'b10, 1'b1, 2'd1, 8'h5A, 8'd1,   8'd1,   8'd1,   8'd255, 4'd0,  4'd0, 8'd0, 8'h00},
        '{2'b00, 1'b0, 2'd3, 8'hFF, 8'd7,   8'd4,   8'd3,   8'd2,   4'd15, 4'd0, 8'd3, 8'h00},
        '{2'b10, 1'b0, 2'd3, 8'h00, 8'd0,   8'd0,   8'd0,   8'd0,   4'd15, 4'd0, 8'd0, 8'h81},
        '{2'b10, 1'b1, 2'd0, 8'h99, 8'd255, 8'd255, 8'd255, 8'd255, 4'd0,  4'd0, 8'd0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic       req_write = 1'b0;
    logic [7:0] req_wdata = 8'h00;
    logic [1:0] req_bank = 2'd0;
    logic [3:0] cfg_cmd_rd_dly = 4'd0;
    logic [3:0] cfg_adr_rd_dly = 4'd0;
    logic [7:0] cfg_hiz = 8'd0;
    logic [7:0] cfg_setup = 8'd0;
    logic [7:0] cfg_wait = 8'd0;
    logic [7:0] cfg_hold = 8'd0;
    logic       dev_wait = 1'b0;
    logic [7:0] dq_in = 8'h00;
    logic       busy, done, cle, ale, we_n, re_n, dq_oe;
    logic [7:0] rdata, dq_out;
    logic [3:0] ce_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int last_latch = 0;  // bench model: 0 none, 1 command, 2 address

    nand_strobe_seq u_nand_strobe_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .req_bank      (req_bank),
        .cfg_cmd_rd_dly(cfg_cmd_rd_dly),
        .cfg_adr_rd_dly(cfg_adr_rd_dly),
        .cfg_hiz       (cfg_hiz),
        .cfg_setup     (cfg_setup),
        .cfg_wait      (cfg_wait),
        .cfg_hold      (cfg_hold),
        .dev_wait      (dev_wait),
        .dq_in         (dq_in),
        .busy          (busy),
        .done          (done),
        .rdata         (rdata),
        .cle           (cle),
        .ale           (ale),
        .ce_n          (ce_n),
        .we_n          (we_n),
        .re_n          (re_n),
        .dq_out        (dq_out),
        .dq_oe         (dq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk("R1", {tag, " busy"}, int'(busy), 0);
        chk("R1", {tag, " done"}, int'(done), 0);
        chk("R1", {tag, " ce_n"}, int'(ce_n), 15);
        chk("R1", {tag, " we_n/re_n"}, int'({we_n, re_n}), 3);
        chk("R1", {tag, " cle/ale/oe"}, int'({cle, ale, dq_oe}), 0);
    endtask

    // Issue one access at a falling edge and measure every phase at the pins.
    task automatic run_access(input vec_t v, input bit intrude);
        bit is_wr, turn, seen_done;
        int dly, exp_pre, exp_stb, exp_post, total, exp_lo;
        int pre, stb, post, cle_n, ale_n, ce_err, stb_err, dq_err;
        int oe_lo, oe_hi, oe_gap, stall_left;
        is_wr = !v.kind[1] || v.wr;
        turn  = !is_wr && (last_latch != 0);
        dly   = (last_latch == 1) ? int'(v.clr) : int'(v.alr);
        exp_pre  = (turn ? dly + 1 : 0) + int'(v.setup) + 1;
        exp_stb  = int'(v.wt) + 1 + int'(v.stall);
        exp_post = int'(v.hold) + 1;
        total    = exp_pre + exp_stb + exp_post;
        exp_lo   = (int'(v.hiz) < total) ? int'(v.hiz) : total;
        pre = 0; stb = 0; post = 0; cle_n = 0; ale_n = 0; ce_err = 0; stb_err = 0;
        dq_err = 0; oe_lo = 0; oe_hi = 0; oe_gap = 0; stall_left = 0; seen_done = 0;

        req_kind = v.kind; req_write = v.wr; req_wdata = v.wdata; req_bank = v.bank;
        cfg_cmd_rd_dly = v.clr; cfg_adr_rd_dly = v.alr; cfg_hiz = v.hiz;
        cfg_setup = v.setup; cfg_wait = v.wt; cfg_hold = v.hold;
        dq_in = v.rdv; dev_wait = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin
                seen_done = 1;
                break;
            end
            if (!busy) break;
            if (stall_left > 0) begin
                stall_left--;
                if (stall_left == 0) dev_wait = 1'b0;
            end
            if (!we_n || !re_n) begin
                stb++;
                if (is_wr ? !re_n : !we_n) stb_err++;
                if (is_wr && dq_out != v.wdata) dq_err++;
                if (stb == 1 && v.stall != 0) begin
                    dev_wait = 1'b1;
                    stall_left = int'(v.stall);
                end
            end else if (stb == 0) begin
                pre++;
            end else begin
                post++;
                if (post == 1 && !is_wr) dq_in = ~v.rdv;
            end
            cle_n += int'(cle);
            ale_n += int'(ale);
            if (ce_n != ~(4'b0001 << v.bank)) ce_err++;
            if (dq_oe) oe_hi++;
            else if (oe_hi == 0) oe_lo++;
            else oe_gap++;
            if (intrude && i == 1) begin
                req_valid = 1'b1; req_kind = 2'b01; cfg_hold = 8'd9;
                cfg_setup = 8'd0; req_bank = v.bank ^ 2'd3;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;

        chk("R2", "setup/turnaround cycles", pre, exp_pre);
        chk("R3", "strobe cycles incl R4 stall", stb, exp_stb);
        chk("R5", "hold cycles", post, exp_post);
        chk("R5", "done seen", int'(seen_done), 1);
        chk("R2", "cle cycles", cle_n, (v.kind == 2'b00) ? total : 0);
        chk("R2", "ale cycles", ale_n, (v.kind == 2'b01) ? total : 0);
        chk("R3", "wrong strobe cycles", stb_err, 0);
        chk("R9", "chip enable mismatches", ce_err, 0);
        if (is_wr) begin
            chk("R6", "tristate cycles", oe_lo, exp_lo);
            chk("R6", "driven cycles", oe_hi, total - exp_lo);
            chk("R6", "enable gaps", oe_gap, 0);
            chk("R6", "write byte", dq_err, 0);
        end else begin
            chk("R6", "read drive cycles", oe_hi, 0);
            chk("R8", "read byte", int'(rdata), int'(v.rdv));
        end
        @(negedge clk);
        chk("R5", "done single cycle", int'(done), 0);
        chk("R10", "no access after done", int'(busy), 0);
        last_latch = (v.kind == 2'b00) ? 1 : (v.kind == 2'b01) ? 2 : 0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        vec_t iv;
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        chk("R1", "rdata after reset", int'(rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle");

        // Table of vectors; latch history chains through consecutive entries (R7).
        for (int k = 0; k < NVEC; k++) begin
            run_access(VECS[k], 1'b0);
        end

        // R10: competing request and changed timing during a command access.
        iv = '{2'b00, 1'b1, 2'd1, 8'h3E, 8'd1, 8'd1, 8'd1, 8'd0, 4'd2, 4'd0, 8'd0, 8'h00};
        run_access(iv, 1'b1);

        // R1/R7: reset in mid-access returns to idle and clears latch history.
        iv = '{2'b01, 1'b1, 2'd2, 8'h44, 8'd5, 8'd5, 8'd5, 8'd0, 4'd0, 4'd0, 8'd0, 8'h00};
        req_kind = iv.kind; req_write = iv.wr; req_bank = iv.bank; cfg_setup = iv.setup;
        cfg_wait = iv.wt; cfg_hold = iv.hold; cfg_hiz = 8'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", "busy before reset", int'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1 mid reset");
        rst_n = 1'b1;
        last_latch = 0;
        @(negedge clk);
        iv = '{2'b10, 1'b0, 2'd0, 8'h00, 8'd0, 8'd1, 8'd0, 8'd0, 4'd7, 4'd7, 8'd0, 8'h6B};
        run_access(iv, 1'b0);  // R7: no delay expected after reset

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule